// File: doc/BRIEF.md
# I2C Bit-Rate and Setup-Time Generator

This block sets the timing of SCL for an I2C master that runs in standard or fast mode. It takes two 32-bit register words and a 2-bit speed-mode field. The first register word holds a baud count N. The second holds a setup count C. From these the block produces three outputs for the bus engine: single-cycle ticks at the start of each SCL high phase and at the start of each low phase, a registered copy of the intended SCL level, and a strobe that fires once the data setup time has run out after a clock stretch.

The bit period is N times 2 in standard mode and N times 3 in the fast modes. In the fast modes the low phase takes two thirds of the period. A new baud count or a new mode is picked up only at a bit boundary, which is the cycle of a fall tick. The bus engine pulses the stretch-release input when it lets SCL go after a stretch. The block then counts C+1 clock cycles and raises the setup strobe, which is the first point at which SDA may change.

Top module: `i2c_rate_gen`

## Requirements
- R1: While `enable` is high and the SCL timer is idle, each clock edge captures `baud_word[15:0]` as N and also captures `speed_mode`. Bits 31:16 of `baud_word` have no effect. The edge that captures a nonzero N starts a low phase and drives `scl_level` to 0.
- R2: For speed-mode codes 0 (standard) and 2 (high speed, which uses standard timing here), the low phase and the high phase each last N cycles. Counting the start edge as edge 0, `scl_rise_tick` follows edge N and `scl_fall_tick` follows edge 2N. This pattern repeats every 2N cycles.
- R3: For speed-mode codes 1 (fast) and 3 (fast plus), the low phase lasts 2N cycles and the high phase lasts N cycles. The rise tick follows edge 2N and the fall tick follows edge 3N.
- R4: Each tick lasts one cycle. The two ticks are never high in the same cycle, and they alternate, starting with a rise tick. `scl_level` is 1 in every cycle in which a rise tick is high and 0 in every cycle in which a fall tick is high.
- R5: An N of zero keeps the timer idle. No ticks are produced and `scl_level` stays at 1. Writing a nonzero N while `enable` is high starts the timer at the next edge.
- R6: A change to `baud_word` or `speed_mode` in the middle of a bit does not affect that bit. The new values are captured at the edge that raises the fall tick, and they set the length of the following bit.
- R7: When `enable` is low at an edge, both ticks and `setup_done` are 0 and `scl_level` is 1 after that edge. Raising `enable` again restarts the timing from the start of a low phase.
- R8: A `stretch_release` pulse loads C from `setup_word[31:16]`. Bits 15:0 of that word have no effect. `setup_done` is then high for exactly one cycle, C+1 edges after the capture edge, so a C of 0 gives a delay of one cycle.
- R9: A `stretch_release` that arrives while the setup count is running restarts the count from the newly captured C. `setup_done` is 0 in the cycle after any capture edge.
- R10: A `stretch_release` seen while `enable` is low is ignored, and no `setup_done` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Peripheral enable; low holds the block idle |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 high speed, 3 fast plus |
| baud_word | input | 32 | Baud register; N sits in bits 15:0 |
| setup_word | input | 32 | Setup register; C sits in bits 31:16 |
| stretch_release | input | 1 | Pulse from the bus engine when SCL is let go after a stretch |
| scl_rise_tick | output | 1 | One-cycle pulse at the start of the SCL high phase |
| scl_fall_tick | output | 1 | One-cycle pulse at the start of the SCL low phase (bit boundary) |
| scl_level | output | 1 | Registered intended SCL level |
| setup_done | output | 1 | One-cycle strobe when the setup delay has expired |

## Verification
Every output comes from a register, so each result appears the cycle after the edge that decides it. Counting the capture edge as edge 0, the first rise tick is due after edge N (standard) or edge 2N (fast). The fall tick is due N edges after the rise tick, and `setup_done` is due after edge C+1. The bench drives inputs and samples outputs on the falling edge. It numbers the samples taken after each stimulus and records the sample index of every tick and strobe. It then compares those indices with N+1, 2N+1, 3N+1, C+2 and the like, which are worked out from the requirements. This makes an early or late result by even one cycle a miscompare. Changes in the middle of a bit and retriggers are applied at known sample indices, so that their boundary edges can be computed the same way.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;
  typedef enum logic [1:0] {
    SPD_STD   = 2'd0,
    SPD_FAST  = 2'd1,
    SPD_HIGH  = 2'd2,
    SPD_FPLUS = 2'd3
  } spd_mode_e;

  function automatic logic mode_is_fast(input logic [1:0] m);
    return (m == SPD_FAST) || (m == SPD_FPLUS);
  endfunction
endpackage

// File: rtl/i2c_phase_decode.sv
module i2c_phase_decode #(
  parameter int BAUD_W = 16,
  parameter int CNT_W  = BAUD_W + 2
) (
  input  logic [BAUD_W-1:0] baud,
  input  logic [1:0]        mode,
  output logic [CNT_W-1:0]  low_len,
  output logic [CNT_W-1:0]  high_len,
  output logic              nonzero
);
  import i2c_rate_pkg::*;

  always_comb begin
    high_len = CNT_W'(baud);
    if (mode_is_fast(mode)) low_len = CNT_W'(baud) << 1;
    else                    low_len = CNT_W'(baud);
    nonzero = (baud != '0);
  end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] low_len_in,
  input  logic [CNT_W-1:0] high_len_in,
  input  logic             nonzero_in,
  output logic             rise_tick,
  output logic             fall_tick,
  output logic             scl_q
);
  logic             running;
  logic             in_high;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] high_len;
  logic [CNT_W-1:0] cur_last;

  assign cur_last = (in_high ? high_len : low_len) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      running   <= 1'b0;
      in_high   <= 1'b0;
      cnt       <= '0;
      low_len   <= '0;
      high_len  <= '0;
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      scl_q     <= 1'b1;
    end else begin
      rise_tick <= 1'b0;
      fall_tick <= 1'b0;
      if (!running) begin
        low_len  <= low_len_in;
        high_len <= high_len_in;
        cnt      <= '0;
        in_high  <= 1'b0;
        running  <= nonzero_in;
        scl_q    <= !nonzero_in;
      end else if (cnt == cur_last) begin
        cnt <= '0;
        if (!in_high) begin
          in_high   <= 1'b1;
          scl_q     <= 1'b1;
          rise_tick <= 1'b1;
        end else begin
          in_high   <= 1'b0;
          scl_q     <= 1'b0;
          fall_tick <= 1'b1;
          low_len   <= low_len_in;
          high_len  <= high_len_in;
          running   <= nonzero_in;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/i2c_setup_timer.sv
module i2c_setup_timer #(
  parameter int SETUP_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               release_in,
  input  logic [SETUP_W-1:0] count_in,
  output logic               done
);
  logic               busy;
  logic [SETUP_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      busy   <= 1'b0;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (release_in) begin
        remain <= count_in;
        busy   <= 1'b1;
      end else if (busy) begin
        if (remain == '0) begin
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          remain <= remain - SETUP_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen #(
  parameter int REG_W   = 32,
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [1:0]       speed_mode,
  input  logic [REG_W-1:0] baud_word,
  input  logic [REG_W-1:0] setup_word,
  input  logic             stretch_release,
  output logic             scl_rise_tick,
  output logic             scl_fall_tick,
  output logic             scl_level,
  output logic             setup_done
);
  localparam int CNT_W     = BAUD_W + 2;
  localparam int SETUP_LSB = REG_W - SETUP_W;

  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] high_len;
  logic             baud_nz;
  logic             unused_fields;

  assign unused_fields = ^{baud_word[REG_W-1:BAUD_W], setup_word[SETUP_LSB-1:0]};

  i2c_phase_decode #(.BAUD_W(BAUD_W), .CNT_W(CNT_W)) u_decode (
    .baud     (baud_word[BAUD_W-1:0]),
    .mode     (speed_mode),
    .low_len  (low_len),
    .high_len (high_len),
    .nonzero  (baud_nz)
  );

  i2c_scl_timer #(.CNT_W(CNT_W)) u_scl (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .low_len_in  (low_len),
    .high_len_in (high_len),
    .nonzero_in  (baud_nz),
    .rise_tick   (scl_rise_tick),
    .fall_tick   (scl_fall_tick),
    .scl_q       (scl_level)
  );

  i2c_setup_timer #(.SETUP_W(SETUP_W)) u_setup (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .release_in (stretch_release),
    .count_in   (setup_word[REG_W-1:SETUP_LSB]),
    .done       (setup_done)
  );
endmodule

// File: rtl/i2c_rate_gen_chk.sv
module i2c_rate_gen_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic stretch_release,
  input logic scl_rise_tick,
  input logic scl_fall_tick,
  input logic scl_level,
  input logic setup_done
);
  logic seen_rise;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      seen_rise <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (scl_rise_tick)      seen_rise <= 1'b1;
      else if (scl_fall_tick) seen_rise <= 1'b0;
      if (stretch_release)    armed <= 1'b1;
      else if (setup_done)    armed <= 1'b0;
    end
  end

  p_no_dual_tick_r4: assert property (@(posedge clk) disable iff (rst)
    !(scl_rise_tick && scl_fall_tick));
  p_rise_level_r4: assert property (@(posedge clk) disable iff (rst)
    scl_rise_tick |-> scl_level);
  p_fall_level_r4: assert property (@(posedge clk) disable iff (rst)
    scl_fall_tick |-> !scl_level);
  p_rise_order_r4: assert property (@(posedge clk) disable iff (rst)
    scl_rise_tick |-> !seen_rise);
  p_fall_order_r4: assert property (@(posedge clk) disable iff (rst)
    scl_fall_tick |-> seen_rise);
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (scl_level && !scl_rise_tick && !scl_fall_tick && !setup_done));
  p_done_needs_release_r8: assert property (@(posedge clk) disable iff (rst)
    setup_done |-> armed);
  p_release_clears_r9: assert property (@(posedge clk) disable iff (rst)
    stretch_release |=> !setup_done);
endmodule

bind i2c_rate_gen i2c_rate_gen_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .enable          (enable),
  .stretch_release (stretch_release),
  .scl_rise_tick   (scl_rise_tick),
  .scl_fall_tick   (scl_fall_tick),
  .scl_level       (scl_level),
  .setup_done      (setup_done)
);

// File: tb/tb_i2c_rate_gen.sv
module tb_i2c_rate_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [1:0]  speed_mode = 2'd0;
  logic [31:0] baud_word = '0;
  logic [31:0] setup_word = '0;
  logic        stretch_release = 1'b0;
  logic        scl_rise_tick, scl_fall_tick, scl_level, setup_done;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;
  int idx;
  int nr, nf, nd;
  int rise_at[16];
  int fall_at[16];
  int done_at[16];

  always #10 clk = ~clk;

  i2c_rate_gen dut (
    .clk(clk), .rst(rst), .enable(enable), .speed_mode(speed_mode),
    .baud_word(baud_word), .setup_word(setup_word),
    .stretch_release(stretch_release), .scl_rise_tick(scl_rise_tick),
    .scl_fall_tick(scl_fall_tick), .scl_level(scl_level), .setup_done(setup_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    idx = 0; nr = 0; nf = 0; nd = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idx++;
    if (scl_rise_tick && nr < 16) begin rise_at[nr] = idx; nr++; end
    if (scl_fall_tick && nf < 16) begin fall_at[nf] = idx; nf++; end
    if (setup_done && nd < 16) begin done_at[nd] = idx; nd++; end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; enable = 1'b0; stretch_release = 1'b0;
    speed_mode = 2'd0; baud_word = '0; setup_word = '0;
    steps(2);
    rst = 1'b0;
    step();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(scl_level == 1'b1, "R7 reset scl_level", scl_level, 1);
    chk(!scl_rise_tick && !scl_fall_tick && !setup_done, "R7 reset outputs quiet",
        {scl_rise_tick, scl_fall_tick, setup_done}, 0);
  endtask

  task automatic t_standard();
    do_reset();
    baud_word = 32'hABCD_0005; speed_mode = 2'd0; enable = 1'b1;
    clear_log();
    step();
    chk(scl_level == 1'b0, "R1 start drives scl low", scl_level, 0);
    steps(24);
    chk(nr >= 2 && rise_at[0] == 6, "R1 R2 first rise, upper baud bits ignored", rise_at[0], 6);
    chk(nf >= 2 && fall_at[0] == 11, "R2 first fall", fall_at[0], 11);
    chk(rise_at[1] == 16 && fall_at[1] == 21, "R2 second period", rise_at[1] * 100 + fall_at[1], 1621);
  endtask

  task automatic t_mode_high_speed();
    do_reset();
    baud_word = 32'd3; speed_mode = 2'd2; enable = 1'b1;
    clear_log();
    steps(10);
    chk(nr >= 1 && nf >= 1 && rise_at[0] == 4 && fall_at[0] == 7, "R2 mode 2 uses standard timing",
        rise_at[0] * 100 + fall_at[0], 407);
  endtask

  task automatic t_fast();
    do_reset();
    baud_word = 32'd4; speed_mode = 2'd1; enable = 1'b1;
    clear_log();
    steps(28);
    chk(nr >= 2 && rise_at[0] == 9, "R3 fast low phase 2N", rise_at[0], 9);
    chk(nf >= 2 && fall_at[0] == 13, "R3 fast high phase N", fall_at[0], 13);
    chk(rise_at[1] == 21 && fall_at[1] == 25, "R3 fast second period", rise_at[1] * 100 + fall_at[1], 2125);
  endtask

  task automatic t_fast_plus();
    do_reset();
    baud_word = 32'd2; speed_mode = 2'd3; enable = 1'b1;
    clear_log();
    steps(14);
    chk(nr >= 2 && nf >= 2 && rise_at[0] == 5 && fall_at[0] == 7 && rise_at[1] == 11 && fall_at[1] == 13,
        "R3 fast plus timing", rise_at[1] * 100 + fall_at[1], 1113);
    chk(nr == 2 && nf == 2, "R4 tick count alternates", nr * 10 + nf, 22);
  endtask

  task automatic t_baud_zero();
    do_reset();
    baud_word = 32'hFFFF_0000; enable = 1'b1;
    clear_log();
    steps(30);
    chk(nr == 0 && nf == 0, "R5 zero baud gives no ticks", nr + nf, 0);
    chk(scl_level == 1'b1, "R5 zero baud keeps scl high", scl_level, 1);
    baud_word = 32'd2;
    clear_log();
    steps(6);
    chk(nr >= 1 && nf >= 1 && rise_at[0] == 3 && fall_at[0] == 5, "R5 nonzero write starts",
        rise_at[0] * 100 + fall_at[0], 305);
  endtask

  task automatic t_midbit_change();
    do_reset();
    baud_word = 32'd4; speed_mode = 2'd0; enable = 1'b1;
    clear_log();
    steps(2);
    baud_word = 32'd6;
    steps(20);
    chk(nr >= 2 && nf >= 2 && rise_at[0] == 5 && fall_at[0] == 9, "R6 current bit keeps old baud",
        rise_at[0] * 100 + fall_at[0], 509);
    chk(rise_at[1] == 15 && fall_at[1] == 21, "R6 next bit uses new baud",
        rise_at[1] * 100 + fall_at[1], 1521);
    do_reset();
    baud_word = 32'd4; speed_mode = 2'd0; enable = 1'b1;
    clear_log();
    steps(2);
    baud_word = 32'd3; speed_mode = 2'd1;
    steps(18);
    chk(nr >= 2 && nf >= 2 && fall_at[0] == 9 && rise_at[1] == 15 && fall_at[1] == 18,
        "R6 mode change at boundary", rise_at[1] * 100 + fall_at[1], 1518);
  endtask

  task automatic t_disable();
    do_reset();
    baud_word = 32'd3; speed_mode = 2'd0; enable = 1'b1; setup_word = {16'd10, 16'd0};
    clear_log();
    stretch_release = 1'b1;
    step();
    stretch_release = 1'b0;
    steps(3);
    enable = 1'b0;
    clear_log();
    steps(12);
    chk(nr == 0 && nf == 0 && nd == 0, "R7 disabled outputs quiet", nr + nf + nd, 0);
    chk(scl_level == 1'b1, "R7 disabled scl high", scl_level, 1);
    enable = 1'b1;
    clear_log();
    steps(8);
    chk(nr >= 1 && nf >= 1 && rise_at[0] == 4 && fall_at[0] == 7, "R7 re-enable restarts",
        rise_at[0] * 100 + fall_at[0], 407);
  endtask

  task automatic run_setup(input int c, input int expect_idx, input string req);
    do_reset();
    enable = 1'b1; setup_word = {16'(c), 16'hFFFF};
    clear_log();
    stretch_release = 1'b1;
    step();
    stretch_release = 1'b0;
    steps(c + 8);
    chk(nd == 1 && done_at[0] == expect_idx, req, (nd == 1) ? done_at[0] : -nd, expect_idx);
  endtask

  task automatic t_setup();
    run_setup(0, 2, "R8 setup count zero waits one cycle");
    run_setup(7, 9, "R8 setup count 7, low bits ignored");
  endtask

  task automatic t_retrigger();
    do_reset();
    enable = 1'b1; setup_word = {16'd5, 16'd0};
    clear_log();
    stretch_release = 1'b1;
    step();
    stretch_release = 1'b0;
    steps(2);
    stretch_release = 1'b1;
    step();
    stretch_release = 1'b0;
    steps(12);
    chk(nd == 1 && done_at[0] == 10, "R9 retrigger restarts count", (nd == 1) ? done_at[0] : -nd, 10);
  endtask

  task automatic t_setup_disabled();
    do_reset();
    enable = 1'b0; setup_word = {16'd2, 16'd0};
    clear_log();
    stretch_release = 1'b1;
    step();
    stretch_release = 1'b0;
    enable = 1'b1;
    steps(10);
    chk(nd == 0, "R10 release while disabled ignored", nd, 0);
  endtask

  initial begin
    t_reset_state();
    t_standard();
    t_mode_high_speed();
    t_fast();
    t_fast_plus();
    t_baud_zero();
    t_midbit_change();
    t_disable();
    t_setup();
    t_retrigger();
    t_setup_disabled();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule